// File: doc/BRIEF.md
# Descriptor-List Audio DMA Walker

This block moves the sample data of one audio stream between system memory and the stream's FIFO. It follows a circular list of buffer descriptors held in memory. Each descriptor names a buffer by its 64-bit address and its byte length, and it carries a flag that requests an interrupt once the buffer has been fully consumed. The block fetches each descriptor through a single request/acknowledge memory port. It then transfers the buffer in 32-bit words, splitting the work into chunks no larger than the programmed FIFO size.

The mode is taken when `enable` rises. In output mode, memory words are read and pushed into the FIFO. If the FIFO has no free room at the start of a chunk, the block halts and flags an overflow. In input mode, FIFO words are popped and written to memory. When the FIFO is empty, a chunk of zero words is written instead, so the stream keeps advancing rather than stalling. After the last valid index, the walk wraps to entry 0 and continues until `enable` is dropped.

Top module: `bdl_dma_stepper`

## Requirements
- R1: Entry k is read from list_base + 16*k as four little-endian 32-bit words at byte offsets 0, 4, 8 and 12. These hold, in that order, the buffer address low half, the buffer address high half, the buffer length in bytes, and the flags, where bit 0 requests a completion interrupt.
- R2: When list_base is zero at a point where a descriptor would be fetched, no memory request is issued. `halted_no_base` goes high and stays high until `enable` is low.
- R3: Loading an entry sets `cur_offset` to 0 and `cur_index` to that entry's index. The next entry after `last_index` is entry 0.
- R4: An entry is complete when its length in words (length bits 31:2; bits 1:0 are ignored) is zero, or when the offset has reached it. A zero-length entry performs no data beat.
- R5: Each data beat uses address buffer address + `cur_offset` and moves one 32-bit word, and the offset advances by 4 per beat.
- R6: A chunk has as many words as the smallest of: the remaining words, `fifo_size` (0 acts as 1), and the FIFO free space in output mode or the FIFO level in input mode (when that level is nonzero).
- R7: In output mode, if `fifo_space` is zero at the start of a chunk, the block stops with `halted_overflow` high and issues no further request or push until `enable` is low.
- R8: In input mode, FIFO words are written to memory in pop order. If `fifo_level` is zero at the start of a chunk, that chunk writes zero words and pops nothing.
- R9: `ioc_event` pulses for one cycle when an entry whose flag bit 0 is set completes. Entries with the flag clear raise no pulse.
- R10: With `enable` low, the block returns to idle at the next chunk or entry boundary and clears both halt flags. Raising `enable` again restarts the walk at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the list walk; the mode is sampled on start |
| dir_in | input | 1 | 1 = input mode (FIFO to memory), 0 = output mode |
| list_base | input | 64 | Byte address of descriptor entry 0 |
| last_index | input | IDX_W | Highest valid entry index before wrap |
| fifo_size | input | FCNT_W | Programmed FIFO size in words, caps each chunk |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Completes the pending request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| fifo_push | output | 1 | Push one word into the FIFO (output mode) |
| fifo_push_data | output | 32 | Word pushed |
| fifo_space | input | FCNT_W | Free FIFO words |
| fifo_pop | output | 1 | Pop the head word (input mode) |
| fifo_pop_data | input | 32 | Head word of the FIFO |
| fifo_level | input | FCNT_W | Words held in the FIFO |
| ioc_event | output | 1 | One-cycle completion interrupt pulse |
| halted_overflow | output | 1 | Stopped because the FIFO was full |
| halted_no_base | output | 1 | Stopped because list_base was zero |
| cur_index | output | IDX_W | Index of the loaded entry |
| cur_offset | output | 32 | Byte offset within the loaded buffer |

## Verification
The hardest situation to reach from the ports is a chunk cut short by the FIFO rather than by the buffer. In that case the free space or fill level runs out partway through an entry, and the next decision has to be a halt or a switch to silence. The bench builds a FIFO model whose free space shrinks with every push, and a source queue holding fewer words than the buffer needs. This forces a short chunk, followed by an overflow halt in output mode, or by a zero-filled remainder in input mode. Chunk lengths are measured from the gaps in the request pattern. That makes the cap from `fifo_size` and from the FIFO state visible without looking inside the design.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

   localparam int DESC_BYTES_LG2 = 4;
   localparam int WORD_BYTES_LG2 = 2;
   localparam int IOC_FLAG_BIT   = 0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_PLAN,
      ST_XFER,
      ST_GAP,
      ST_HALT
   } walk_state_t;

endpackage

// File: rtl/bdl_chunk_calc.sv
module bdl_chunk_calc #(
   parameter int FCNT_W = 8
) (
   input  logic [29:0]       rem_words,
   input  logic [FCNT_W-1:0] fifo_size,
   input  logic [FCNT_W-1:0] fifo_space,
   input  logic [FCNT_W-1:0] fifo_level,
   input  logic              dir_in,
   output logic [FCNT_W-1:0] chunk,
   output logic              zero_fill,
   output logic              no_space
);

   logic [FCNT_W-1:0] size_eff;
   logic [FCNT_W-1:0] rem_cap;
   logic [FCNT_W-1:0] fifo_lim;

   always_comb begin
      size_eff = (fifo_size == '0) ? FCNT_W'(1) : fifo_size;
      rem_cap  = (rem_words > 30'(size_eff)) ? size_eff : rem_words[FCNT_W-1:0];
      if (dir_in) begin
         fifo_lim = (fifo_level == '0) ? '1 : fifo_level;
      end else begin
         fifo_lim = fifo_space;
      end
      chunk     = (rem_cap < fifo_lim) ? rem_cap : fifo_lim;
      zero_fill = dir_in && (fifo_level == '0);
      no_space  = !dir_in && (fifo_space == '0);
   end

endmodule

// File: rtl/bdl_addr_gen.sv
module bdl_addr_gen #(
   parameter int IDX_W = 8
) (
   input  logic [63:0]      list_base,
   input  logic [IDX_W-1:0] fetch_idx,
   input  logic [1:0]       word_sel,
   input  logic [63:0]      buf_addr,
   input  logic [31:0]      offset,
   input  logic             sel_fetch,
   output logic [63:0]      addr
);
   import bdl_pkg::*;

   logic [63:0] desc_addr;
   logic [63:0] data_addr;

   always_comb begin
      desc_addr = list_base
                + (64'(fetch_idx) << DESC_BYTES_LG2)
                + (64'(word_sel) << WORD_BYTES_LG2);
      data_addr = buf_addr + 64'(offset);
      addr      = sel_fetch ? desc_addr : data_addr;
   end

endmodule

// File: rtl/bdl_desc_store.sv
module bdl_desc_store #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_word,
   input  logic [1:0]       word_sel,
   input  logic [31:0]      word_data,
   input  logic [IDX_W-1:0] new_index,
   input  logic             advance,
   output logic [63:0]      buf_addr,
   output logic [29:0]      len_words,
   output logic             ioc_flag,
   output logic [IDX_W-1:0] cur_index,
   output logic [31:0]      cur_offset
);
   import bdl_pkg::*;

   localparam int ADDR_HALVES = 2;

   logic entry_begin;
   assign entry_begin = load_word && (word_sel == 2'd3);

   for (genvar g = 0; g < ADDR_HALVES; g++) begin : g_half
      logic [31:0] half_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            half_q <= '0;
         end else if (load_word && (word_sel == 2'(g))) begin
            half_q <= word_data;
         end
      end
      assign buf_addr[32*g +: 32] = half_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_words  <= '0;
         ioc_flag   <= 1'b0;
         cur_index  <= '0;
         cur_offset <= '0;
      end else begin
         if (load_word && (word_sel == 2'd2)) begin
            len_words <= word_data[31:WORD_BYTES_LG2];
         end
         if (entry_begin) begin
            ioc_flag   <= word_data[IOC_FLAG_BIT];
            cur_index  <= new_index;
            cur_offset <= '0;
         end else if (advance) begin
            cur_offset <= cur_offset + 32'd4;
         end
      end
   end

   p_entry_reset_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      entry_begin |=> (cur_offset == 32'd0) && (cur_index == $past(new_index)));

   p_offset_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!entry_begin && !advance) |=> $stable(cur_offset));

endmodule

// File: rtl/bdl_dma_stepper.sv
module bdl_dma_stepper #(
   parameter int IDX_W  = 8,
   parameter int FCNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              dir_in,
   input  logic [63:0]       list_base,
   input  logic [IDX_W-1:0]  last_index,
   input  logic [FCNT_W-1:0] fifo_size,
   output logic              mem_req,
   output logic              mem_we,
   output logic [63:0]       mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              fifo_push,
   output logic [31:0]       fifo_push_data,
   input  logic [FCNT_W-1:0] fifo_space,
   output logic              fifo_pop,
   input  logic [31:0]       fifo_pop_data,
   input  logic [FCNT_W-1:0] fifo_level,
   output logic              ioc_event,
   output logic              halted_overflow,
   output logic              halted_no_base,
   output logic [IDX_W-1:0]  cur_index,
   output logic [31:0]       cur_offset
);
   import bdl_pkg::*;

   if (IDX_W < 1 || IDX_W > 28) begin : g_bad_idx
      $error("IDX_W out of range");
   end
   if (FCNT_W < 2 || FCNT_W > 30) begin : g_bad_fcnt
      $error("FCNT_W out of range");
   end

   walk_state_t       state;
   logic [1:0]        word_sel;
   logic [IDX_W-1:0]  fetch_idx;
   logic [FCNT_W-1:0] beats_left;
   logic              zero_mode;
   logic              dir_q;
   logic              push_q;
   logic [31:0]       push_data_q;
   logic              pop_q;
   logic              ioc_q;
   logic              ovf_q;
   logic              nobase_q;

   logic [63:0]       buf_addr;
   logic [29:0]       len_words;
   logic              ioc_flag;
   logic [29:0]       off_words;
   logic              entry_done;
   logic [29:0]       rem_words;
   logic [IDX_W-1:0]  next_idx;
   logic [FCNT_W-1:0] chunk;
   logic              zero_fill;
   logic              no_space;
   logic              load_word;
   logic              beat_done;

   always_comb begin
      off_words  = cur_offset[31:WORD_BYTES_LG2];
      entry_done = (len_words == '0) || (off_words >= len_words);
      rem_words  = entry_done ? '0 : (len_words - off_words);
      next_idx   = (cur_index == last_index) ? '0 : cur_index + 1'b1;
      mem_req    = (state == ST_FETCH) || (state == ST_XFER);
      mem_we     = (state == ST_XFER) && dir_q;
      mem_wdata  = zero_mode ? 32'd0 : fifo_pop_data;
      load_word  = (state == ST_FETCH) && mem_ack;
      beat_done  = (state == ST_XFER) && mem_ack;
   end

   bdl_chunk_calc #(.FCNT_W(FCNT_W)) u_chunk (
      .rem_words (rem_words),
      .fifo_size (fifo_size),
      .fifo_space(fifo_space),
      .fifo_level(fifo_level),
      .dir_in    (dir_q),
      .chunk     (chunk),
      .zero_fill (zero_fill),
      .no_space  (no_space)
   );

   bdl_addr_gen #(.IDX_W(IDX_W)) u_addr (
      .list_base(list_base),
      .fetch_idx(fetch_idx),
      .word_sel (word_sel),
      .buf_addr (buf_addr),
      .offset   (cur_offset),
      .sel_fetch(state == ST_FETCH),
      .addr     (mem_addr)
   );

   bdl_desc_store #(.IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_word (load_word),
      .word_sel  (word_sel),
      .word_data (mem_rdata),
      .new_index (fetch_idx),
      .advance   (beat_done),
      .buf_addr  (buf_addr),
      .len_words (len_words),
      .ioc_flag  (ioc_flag),
      .cur_index (cur_index),
      .cur_offset(cur_offset)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         word_sel    <= '0;
         fetch_idx   <= '0;
         beats_left  <= '0;
         zero_mode   <= 1'b0;
         dir_q       <= 1'b0;
         push_q      <= 1'b0;
         push_data_q <= '0;
         pop_q       <= 1'b0;
         ioc_q       <= 1'b0;
         ovf_q       <= 1'b0;
         nobase_q    <= 1'b0;
      end else begin
         push_q <= 1'b0;
         pop_q  <= 1'b0;
         ioc_q  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (enable) begin
                  dir_q <= dir_in;
                  if (list_base == '0) begin
                     nobase_q <= 1'b1;
                     state    <= ST_HALT;
                  end else begin
                     fetch_idx <= '0;
                     word_sel  <= '0;
                     state     <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  word_sel <= word_sel + 2'd1;
                  if (word_sel == 2'd3) begin
                     state <= ST_PLAN;
                  end
               end
            end
            ST_PLAN: begin
               if (entry_done) begin
                  ioc_q <= ioc_flag;
                  if (!enable) begin
                     state <= ST_IDLE;
                  end else if (list_base == '0) begin
                     nobase_q <= 1'b1;
                     state    <= ST_HALT;
                  end else begin
                     fetch_idx <= next_idx;
                     word_sel  <= '0;
                     state     <= ST_FETCH;
                  end
               end else if (!enable) begin
                  state <= ST_IDLE;
               end else if (no_space) begin
                  ovf_q <= 1'b1;
                  state <= ST_HALT;
               end else begin
                  beats_left <= chunk;
                  zero_mode  <= zero_fill;
                  state      <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (mem_ack) begin
                  beats_left  <= beats_left - 1'b1;
                  push_q      <= !dir_q;
                  push_data_q <= mem_rdata;
                  pop_q       <= dir_q && !zero_mode;
                  state       <= ST_GAP;
               end
            end
            ST_GAP: begin
               state <= (beats_left == '0) ? ST_PLAN : ST_XFER;
            end
            ST_HALT: begin
               if (!enable) begin
                  ovf_q    <= 1'b0;
                  nobase_q <= 1'b0;
                  state    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign fifo_push       = push_q;
   assign fifo_push_data  = push_data_q;
   assign fifo_pop        = pop_q;
   assign ioc_event       = ioc_q;
   assign halted_overflow = ovf_q;
   assign halted_no_base  = nobase_q;

   p_no_base_quiet_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      halted_no_base |-> !mem_req);

   p_halt_exclusive_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !(halted_no_base && halted_overflow));

   p_push_step_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> (cur_offset == $past(cur_offset) + 32'd4));

   p_ovf_quiet_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      halted_overflow |-> (!mem_req && !fifo_push));

   p_pop_after_write_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> $past(mem_req && mem_we && mem_ack));

   p_zero_no_pop_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && zero_mode) |-> (mem_wdata == 32'd0));

   p_ioc_single_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      ioc_event |=> !ioc_event);

endmodule

// File: tb/bdl_dma_stepper_bench.sv
module bdl_dma_stepper_bench;

   localparam int IDX_W  = 8;
   localparam int FCNT_W = 8;
   localparam int LOGN   = 512;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enable = 1'b0;
   logic              dir_in = 1'b0;
   logic [63:0]       list_base = '0;
   logic [IDX_W-1:0]  last_index = '0;
   logic [FCNT_W-1:0] fifo_size = 8'd4;
   logic              mem_req, mem_we;
   logic [63:0]       mem_addr;
   logic [31:0]       mem_wdata;
   logic              mem_ack = 1'b0;
   logic [31:0]       mem_rdata = '0;
   logic              fifo_push;
   logic [31:0]       fifo_push_data;
   logic [FCNT_W-1:0] fifo_space;
   logic              fifo_pop;
   logic [31:0]       fifo_pop_data;
   logic [FCNT_W-1:0] fifo_level;
   logic              ioc_event, halted_overflow, halted_no_base;
   logic [IDX_W-1:0]  cur_index;
   logic [31:0]       cur_offset;

   always #5 clk = ~clk;

   bdl_dma_stepper #(.IDX_W(IDX_W), .FCNT_W(FCNT_W)) u_bdl_dma_stepper (
      .clk(clk), .rst_n(rst_n), .enable(enable), .dir_in(dir_in),
      .list_base(list_base), .last_index(last_index), .fifo_size(fifo_size),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .fifo_push(fifo_push), .fifo_push_data(fifo_push_data), .fifo_space(fifo_space),
      .fifo_pop(fifo_pop), .fifo_pop_data(fifo_pop_data), .fifo_level(fifo_level),
      .ioc_event(ioc_event), .halted_overflow(halted_overflow), .halted_no_base(halted_no_base),
      .cur_index(cur_index), .cur_offset(cur_offset)
   );

   // stimulus-owned state
   logic [31:0] init_mem [0:1023];
   logic [31:0] src_q [0:15];
   int          src_total = 0;
   int          space_budget = 0;
   int          push_base = 0;

   // monitor-owned state
   int          push_cnt = 0, pop_cnt = 0, ioc_cnt = 0, wr_n = 0, req_cnt = 0;
   int          burst_n = 0, burst = 0, idx_bad = 0, idx_chg = 0, src_head = 0;
   logic        prev_low = 1'b1;
   logic [IDX_W-1:0] prev_idx = '0;
   logic [31:0] push_log [0:LOGN-1];
   int          ioc_at [0:LOGN-1];
   int          burst_log [0:LOGN-1];
   logic [63:0] wr_addr_log [0:LOGN-1];
   logic [31:0] wr_data_log [0:LOGN-1];

   int tests = 0, fails = 0;

   function automatic logic [FCNT_W-1:0] clamp_cnt(input int v);
      if (v <= 0) return '0;
      if (v > 255) return 8'd255;
      return FCNT_W'(v);
   endfunction

   assign fifo_space    = clamp_cnt(space_budget - (push_cnt - push_base));
   assign fifo_level    = clamp_cnt(src_total - src_head);
   assign fifo_pop_data = src_q[src_head % 16];

   // memory responder and monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (fifo_push) begin
               if (push_cnt < LOGN) push_log[push_cnt] = fifo_push_data;
               push_cnt++;
               burst++;
            end
            if (fifo_pop) begin
               src_head++;
               pop_cnt++;
            end
            if (ioc_event) begin
               if (ioc_cnt < LOGN) ioc_at[ioc_cnt] = push_cnt;
               ioc_cnt++;
            end
            if (!mem_req && prev_low && burst != 0) begin
               if (burst_n < LOGN) burst_log[burst_n] = burst;
               burst_n++;
               burst = 0;
            end
            prev_low = !mem_req;
            if (cur_index != prev_idx) begin
               idx_chg++;
               if (cur_offset != 32'd0) idx_bad++;
               prev_idx = cur_index;
            end
            if (mem_req) req_cnt++;
            if (mem_ack) begin
               mem_ack = 1'b0;
            end else if (mem_req) begin
               if (mem_we) begin
                  if (wr_n < LOGN) begin
                     wr_addr_log[wr_n] = mem_addr;
                     wr_data_log[wr_n] = mem_wdata;
                  end
                  wr_n++;
               end else begin
                  mem_rdata = init_mem[mem_addr[11:2]];
               end
               mem_ack = 1'b1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put_desc(input int base, input int k, input int addr, input int len, input int flags);
      init_mem[(base >> 2) + 4*k + 0] = addr;
      init_mem[(base >> 2) + 4*k + 1] = 32'd0;
      init_mem[(base >> 2) + 4*k + 2] = len;
      init_mem[(base >> 2) + 4*k + 3] = flags;
   endtask

   task automatic stop_run();
      enable = 1'b0;
      repeat (40) @(negedge clk);
   endtask

   task automatic wait_pushes(input int n, input string req);
      int guard = 0;
      while ((push_cnt - push_base) < n && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      chk(guard < 5000, {req, " timeout waiting for pushes"}, push_cnt - push_base, n);
   endtask

   function automatic int max_burst(input int from);
      int m = 0;
      for (int i = from; i < burst_n && i < LOGN; i++) if (burst_log[i] > m) m = burst_log[i];
      return m;
   endfunction

   task automatic t_reset();
      chk(mem_req == 1'b0, "R10 reset: no request", mem_req, 0);
      chk(fifo_push == 1'b0 && fifo_pop == 1'b0, "R10 reset: no FIFO strobe", {fifo_push, fifo_pop}, 0);
      chk(!halted_overflow && !halted_no_base && !ioc_event, "R10 reset: flags clear",
          {halted_overflow, halted_no_base, ioc_event}, 0);
      chk(cur_offset == 0 && cur_index == 0, "R3 reset: offset and index zero", cur_offset, 0);
   endtask

   // R1 R3 R5 R6 R9: output walk across two entries with wrap
   task automatic t_output_walk();
      int ib, bb, cb, eb;
      for (int i = 0; i < 6; i++) init_mem[(32'h200 >> 2) + i] = 32'hA000_0000 + i;
      for (int i = 0; i < 2; i++) init_mem[(32'h300 >> 2) + i] = 32'hB000_0000 + i;
      put_desc(32'h100, 0, 32'h200, 24, 1);
      put_desc(32'h100, 1, 32'h300, 8, 0);
      list_base = 64'h100; last_index = 8'd1; fifo_size = 8'd4; dir_in = 1'b0;
      space_budget = 1000; push_base = push_cnt;
      ib = ioc_cnt; bb = burst_n; cb = idx_chg; eb = idx_bad;
      enable = 1'b1;
      wait_pushes(14, "R1");
      repeat (20) @(negedge clk);
      stop_run();
      for (int i = 0; i < 14; i++) begin
         logic [31:0] e;
         if (i < 6) e = 32'hA000_0000 + i;
         else if (i < 8) e = 32'hB000_0000 + (i - 6);
         else e = 32'hA000_0000 + (i - 8);
         chk(push_log[push_base + i] == e, "R1 R5 pushed word", push_log[push_base + i], e);
      end
      chk(ioc_cnt - ib >= 2, "R9 two completion pulses", ioc_cnt - ib, 2);
      chk(ioc_at[ib] - push_base == 6, "R9 pulse after entry 0", ioc_at[ib] - push_base, 6);
      chk(ioc_at[ib + 1] - push_base == 14, "R9 no pulse for flagless entry", ioc_at[ib + 1] - push_base, 14);
      chk(max_burst(bb) == 4, "R6 chunk capped by fifo_size", max_burst(bb), 4);
      chk(idx_chg > cb && idx_bad == eb, "R3 offset zero on each entry load", idx_bad - eb, 0);
   endtask

   // R4 R6 R10: zero-length first entry, odd fifo size
   task automatic t_zero_length();
      int ib, bb;
      for (int i = 0; i < 8; i++) init_mem[(32'h280 >> 2) + i] = 32'hC000_0000 + i;
      put_desc(32'h180, 0, 32'h0, 0, 1);
      put_desc(32'h180, 1, 32'h280, 32, 0);
      list_base = 64'h180; last_index = 8'd1; fifo_size = 8'd3; dir_in = 1'b0;
      space_budget = 1000; push_base = push_cnt;
      ib = ioc_cnt; bb = burst_n;
      enable = 1'b1;
      wait_pushes(8, "R4");
      repeat (10) @(negedge clk);
      stop_run();
      chk(ioc_at[ib] - push_base == 0, "R4 R10 zero-length entry 0 completes first", ioc_at[ib] - push_base, 0);
      for (int i = 0; i < 8; i++)
         chk(push_log[push_base + i] == 32'hC000_0000 + i, "R4 data from entry 1",
             push_log[push_base + i], 32'hC000_0000 + i);
      chk(max_burst(bb) == 3, "R6 chunk capped by size 3", max_burst(bb), 3);
   endtask

   // R5 R8 R9: input mode, FIFO runs dry mid-entry
   task automatic t_input_fill();
      int ib, wb, pb, guard;
      put_desc(32'h1C0, 0, 32'h400, 32, 1);
      put_desc(32'h1C0, 1, 32'h800, 4096, 0);
      for (int i = 0; i < 5; i++) src_q[(src_head + i) % 16] = 32'hD000_0000 + i;
      src_total = src_head + 5;
      list_base = 64'h1C0; last_index = 8'd1; fifo_size = 8'd8; dir_in = 1'b1;
      ib = ioc_cnt; wb = wr_n; pb = pop_cnt; guard = 0;
      enable = 1'b1;
      while (ioc_cnt == ib && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      chk(guard < 5000, "R9 completion pulse in input mode", ioc_cnt - ib, 1);
      repeat (5) @(negedge clk);
      stop_run();
      for (int i = 0; i < 8; i++) begin
         logic [31:0] e;
         e = (i < 5) ? 32'hD000_0000 + i : 32'd0;
         chk(wr_addr_log[wb + i] == 64'h400 + 4*i, "R5 write address", wr_addr_log[wb + i], 64'h400 + 4*i);
         chk(wr_data_log[wb + i] == e, "R8 write data / silence", wr_data_log[wb + i], e);
      end
      chk(pop_cnt - pb == 5, "R8 no pops during silence", pop_cnt - pb, 5);
   endtask

   // R6 R7 R10: output FIFO fills up
   task automatic t_overflow();
      int bb, guard;
      list_base = 64'h100; last_index = 8'd1; fifo_size = 8'd8; dir_in = 1'b0;
      space_budget = 3; push_base = push_cnt; bb = burst_n; guard = 0;
      enable = 1'b1;
      while (!halted_overflow && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      repeat (10) @(negedge clk);
      chk(halted_overflow == 1'b1, "R7 overflow flag", halted_overflow, 1);
      chk(push_cnt - push_base == 3, "R7 pushes stop at full", push_cnt - push_base, 3);
      chk(mem_req == 1'b0, "R7 no request while halted", mem_req, 0);
      chk(max_burst(bb) == 3, "R6 chunk capped by free space", max_burst(bb), 3);
      stop_run();
      chk(halted_overflow == 1'b0, "R10 flag clears with enable low", halted_overflow, 0);
   endtask

   // R2 R10: zero list base
   task automatic t_no_base();
      int rb;
      list_base = 64'h0; dir_in = 1'b0; rb = req_cnt;
      enable = 1'b1;
      repeat (20) @(negedge clk);
      chk(halted_no_base == 1'b1, "R2 refused fetch flag", halted_no_base, 1);
      chk(req_cnt == rb, "R2 no memory request", req_cnt - rb, 0);
      stop_run();
      chk(halted_no_base == 1'b0, "R10 refused flag clears", halted_no_base, 0);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      fails++;
      tests++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) init_mem[i] = 32'hDEAD_0000 + i;
      for (int i = 0; i < 16; i++) src_q[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_output_walk();
      t_zero_length();
      t_input_fill();
      t_overflow();
      t_no_base();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule